// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Aggregator

This unit watches one register set of 32 already-synchronised GPIO levels and turns selected transitions into latched interrupt events. Each pin has its own rising-edge and falling-edge enable; either or both may be active. A detected edge sets the pin's bit in a status register, which software clears by writing ones. The status bits are gathered into two 16-pin groups. Each group drives one level-sensitive interrupt line towards the system interrupt controller, and a small group-enable register gates each line.

Edges are found by comparing each pin's level with the level it had on the previous clock. Software sets and removes edge enables through separate set and clear addresses, so read-modify-write is never needed. The unit has no state machine. All of its state is the per-pin previous level, the per-pin status bit, and the enable registers.

Top module: `gpio_edge_irq_unit`

## Requirements
- R1: After reset, the rising enables, the falling enables, the status bits and the group enables all read as zero, and both interrupt lines are low.
- R2: A write to the rising-set address (0x10) sets every rising-enable bit where the data is 1. A write to the rising-clear address (0x14) clears every rising-enable bit where the data is 1. Data bits of 0 leave the enable unchanged. Reading either address returns the rising enables.
- R3: The falling enables behave the same way. The falling-set address is 0x18 and the falling-clear address is 0x1C, and reading either address returns the falling enables.
- R4: A pin whose rising enable is set gets its status bit set at the clock edge that first samples it high after a low sample. A pin whose falling enable is set gets its status bit set at the clock edge that first samples it low after a high sample. An edge of a direction that is not enabled sets nothing.
- R5: A pin with both enables set flags on its rising edge and on its falling edge.
- R6: Writing the status address (0x20) clears each status bit where the data is 1. Data bits of 0 leave the status bit unchanged. Reading 0x20 returns the status bits.
- R7: If an enabled edge occurs in the same cycle as a clear write to that status bit, the bit stays set.
- R8: Interrupt line 0 is the OR of status bits 15:0, and line 1 is the OR of status bits 31:16, each ANDed with its group enable. A line stays high until every status bit of its group is cleared.
- R9: The group-enable register at address 0x08 holds bit g for line g and reads back. While bit g is 0, line g is low, but status bits still latch. Setting bit g later raises the line if any of that group's status bits is set.
- R10: Once a pin's rising and falling enables are both clear, its edges set no status. Status bits that are already set keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 32 | Synchronised pin levels |
| bus_wr | input | 1 | Register write strobe for this cycle |
| bus_addr | input | 6 | Register byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_grp | output | 2 | Level interrupt line per 16-pin group |

## Verification
A wrong internal state shows at the ports within one clock. A stale previous-level bit or a wrong enable bit produces a missing or extra status bit, which is visible on the status readback. The interrupt line of that pin's group shows it too, on the cycle after the edge. The sweep moves every pin through every enable combination, in both directions, in each of the two groups. After every cycle it compares the status readback and both interrupt lines against a model, so a fault in a single bit is exposed at the exact cycle it occurs. The tests also place an edge against a status clear in the same cycle, and toggle the group gate while status is pending, to catch faults in ordering and in gating.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 6;

    // Register byte addresses; the group enable sits at 0x08
    typedef enum logic [ADDR_W-1:0] {
        REG_GRP_EN   = 6'h08,
        REG_RISE_SET = 6'h10,
        REG_RISE_CLR = 6'h14,
        REG_FALL_SET = 6'h18,
        REG_FALL_CLR = 6'h1C,
        REG_STATUS   = 6'h20
    } reg_addr_e;

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int GROUPS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   wdata,
    input  logic [PINS-1:0]   status,
    output logic [PINS-1:0]   rise_en,
    output logic [PINS-1:0]   fall_en,
    output logic [GROUPS-1:0] grp_en,
    output logic [PINS-1:0]   stat_clr,
    output logic [PINS-1:0]   rdata
);

    logic wr_rise_set, wr_rise_clr, wr_fall_set, wr_fall_clr, wr_gen, wr_stat;

    always_comb begin
        wr_rise_set = wr_en && (addr == REG_RISE_SET);
        wr_rise_clr = wr_en && (addr == REG_RISE_CLR);
        wr_fall_set = wr_en && (addr == REG_FALL_SET);
        wr_fall_clr = wr_en && (addr == REG_FALL_CLR);
        wr_gen      = wr_en && (addr == REG_GRP_EN);
        wr_stat     = wr_en && (addr == REG_STATUS);
    end

    assign stat_clr = wr_stat ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            grp_en  <= '0;
        end else begin
            if (wr_rise_set)
                rise_en <= rise_en | wdata;
            else if (wr_rise_clr)
                rise_en <= rise_en & ~wdata;
            if (wr_fall_set)
                fall_en <= fall_en | wdata;
            else if (wr_fall_clr)
                fall_en <= fall_en & ~wdata;
            if (wr_gen)
                grp_en <= wdata[GROUPS-1:0];
        end
    end

    always_comb begin
        case (addr)
            REG_GRP_EN:   rdata = PINS'(grp_en);
            REG_RISE_SET,
            REG_RISE_CLR: rdata = rise_en;
            REG_FALL_SET,
            REG_FALL_CLR: rdata = fall_en;
            REG_STATUS:   rdata = status;
            default:      rdata = '0;
        endcase
    end

    // R2: set write leaves the written ones set
    a_r2_rise_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise_set |=> ((rise_en & $past(wdata)) == $past(wdata)));
    // R2: clear write leaves the written ones clear
    a_r2_rise_clr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise_clr |=> ((rise_en & $past(wdata)) == '0));
    // R3
    a_r3_fall_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fall_set |=> ((fall_en & $past(wdata)) == $past(wdata)));
    a_r3_fall_clr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fall_clr |=> ((fall_en & $past(wdata)) == '0));

endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_lvl,
    input  logic [PINS-1:0] rise_en,
    input  logic [PINS-1:0] fall_en,
    input  logic [PINS-1:0] stat_clr,
    output logic [PINS-1:0] status
);

    logic [PINS-1:0] prev_lvl;
    logic [PINS-1:0] evt;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic rose, fell;
        assign rose   = pin_lvl[i] & ~prev_lvl[i];
        assign fell   = ~pin_lvl[i] & prev_lvl[i];
        assign evt[i] = (rose & rise_en[i]) | (fell & fall_en[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_lvl[i] <= 1'b0;
                status[i]   <= 1'b0;
            end else begin
                prev_lvl[i] <= pin_lvl[i];
                // a new edge outranks a coincident clear
                status[i]   <= evt[i] | (status[i] & ~stat_clr[i]);
            end
        end
    end

    // R6: cleared bits without a coincident edge drop
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_clr) |=> ((status & $past(stat_clr & ~evt)) == '0));
    // R7: an edge always leaves its bit set
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));
    // R10: no status bit rises without a qualified edge
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(evt)) == '0));

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int PINS       = 32,
    parameter int GROUP_PINS = 16,
    localparam int GROUPS    = PINS / GROUP_PINS
) (
    input  logic [PINS-1:0]   status,
    input  logic [GROUPS-1:0] grp_en,
    output logic [GROUPS-1:0] irq
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign irq[g] = (|status[g*GROUP_PINS +: GROUP_PINS]) & grp_en[g];
    end

endmodule

// File: rtl/gpio_edge_irq_unit.sv
module gpio_edge_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int PINS       = 32,
    parameter int GROUP_PINS = 16,
    localparam int GROUPS    = PINS / GROUP_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_lvl,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    output logic [GROUPS-1:0] irq_grp
);

    logic [PINS-1:0]   rise_en, fall_en, stat_clr, status;
    logic [GROUPS-1:0] grp_en;

    gpio_irq_regs #(.PINS(PINS), .GROUPS(GROUPS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .status(status), .rise_en(rise_en),
        .fall_en(fall_en), .grp_en(grp_en), .stat_clr(stat_clr),
        .rdata(bus_rdata)
    );

    gpio_irq_edge #(.PINS(PINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .rise_en(rise_en),
        .fall_en(fall_en), .stat_clr(stat_clr), .status(status)
    );

    gpio_irq_group #(.PINS(PINS), .GROUP_PINS(GROUP_PINS)) u_group (
        .status(status), .grp_en(grp_en), .irq(irq_grp)
    );

    // R1: lines are quiet on the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_grp == '0));

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        // R8: a raised line holds until status or gate is written
        a_r8_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_grp[g] && !(bus_wr && (bus_addr == REG_STATUS))
                        && !(bus_wr && (bus_addr == REG_GRP_EN)))
            |=> irq_grp[g]);
    end

endmodule

// File: tb/test_gpio_edge_irq_unit.sv
module test_gpio_edge_irq_unit;
    import gpio_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int total = 0;
    int bad = 0;

    logic [31:0] m_rise = '0, m_fall = '0, m_stat = '0, m_prev = '0;
    logic [1:0]  m_gen = '0;

    always #5 clk = ~clk;

    gpio_edge_irq_unit i_gpio_edge_irq_unit (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_grp(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_irq();
        return {(|m_stat[31:16]) & m_gen[1], (|m_stat[15:0]) & m_gen[0]};
    endfunction

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        wr = 1'b0;
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    // one clock: drive, update model at the edge, compare after it
    task automatic cyc(input logic [31:0] p, input bit w, input logic [5:0] a,
                       input logic [31:0] d, input string tag);
        logic [31:0] evt;
        pins = p; wr = w; addr = a; wdata = d;
        @(posedge clk);
        evt = (p & ~m_prev & m_rise) | (~p & m_prev & m_fall);
        m_stat = evt | (m_stat & ~((w && a == REG_STATUS) ? d : 32'h0));
        m_prev = p;
        if (w && a == REG_RISE_SET) m_rise = m_rise | d;
        if (w && a == REG_RISE_CLR) m_rise = m_rise & ~d;
        if (w && a == REG_FALL_SET) m_fall = m_fall | d;
        if (w && a == REG_FALL_CLR) m_fall = m_fall & ~d;
        if (w && a == REG_GRP_EN)   m_gen  = d[1:0];
        @(negedge clk);
        rd(REG_STATUS, m_stat, {tag, " status"});
        chk({tag, " irq"}, {30'h0, irq}, {30'h0, exp_irq()});
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(REG_RISE_SET, 32'h0, "R1 rise");
        rd(REG_FALL_SET, 32'h0, "R1 fall");
        rd(REG_STATUS, 32'h0, "R1 status");
        rd(REG_GRP_EN, 32'h0, "R1 group enable");
        chk("R1 irq", {30'h0, irq}, 32'h0);

        // R2 / R3 enable set/clear registers
        cyc(pins, 1, REG_RISE_SET, 32'hA5A5_0000, "R2 set");
        rd(REG_RISE_CLR, 32'hA5A5_0000, "R2 readback");
        cyc(pins, 1, REG_RISE_SET, 32'h0, "R2 zero write");
        rd(REG_RISE_SET, 32'hA5A5_0000, "R2 zero no effect");
        cyc(pins, 1, REG_RISE_CLR, 32'h0500_0000, "R2 clear");
        rd(REG_RISE_SET, 32'hA0A5_0000, "R2 after clear");
        cyc(pins, 1, REG_FALL_SET, 32'h0000_3C3C, "R3 set");
        cyc(pins, 1, REG_FALL_CLR, 32'h0000_0C00, "R3 clear");
        rd(REG_FALL_CLR, 32'h0000_303C, "R3 readback");
        rd(REG_RISE_SET, 32'hA0A5_0000, "R3 rise untouched");
        cyc(pins, 1, REG_GRP_EN, 32'h3, "R9 enable both");
        rd(REG_GRP_EN, 32'h3, "R9 readback");

        // sweep: every pin, every enable combination
        for (int i = 0; i < 32; i++) begin
            for (int mode = 0; mode < 4; mode++) begin
                string t;
                logic [31:0] b;
                b = 32'h1 << i;
                if (mode == 0) t = "R10";
                else if (mode == 3) t = "R5";
                else t = "R4";
                t = $sformatf("R8/%s pin %0d mode %0d", t, i, mode);
                cyc(32'h0, 1, REG_RISE_CLR, 32'hFFFF_FFFF, t);
                cyc(32'h0, 1, REG_FALL_CLR, 32'hFFFF_FFFF, t);
                cyc(32'h0, 1, REG_RISE_SET, mode[0] ? b : 32'h0, t);
                cyc(32'h0, 1, REG_FALL_SET, mode[1] ? b : 32'h0, t);
                cyc(b, 0, REG_STATUS, 32'h0, {t, " rise"});
                cyc(b, 0, REG_STATUS, 32'h0, {t, " hold"});
                cyc(32'h0, 1, REG_STATUS, b & {32{mode == 1}}, {t, " fall"});
                cyc(32'h0, 1, REG_STATUS, 32'hFFFF_FFFF, {t, " R6 clear"});
            end
        end

        // R6 zero write and partial clear; R8 line holds while any bit set
        cyc(32'h0, 1, REG_RISE_SET, 32'hFFFF_FFFF, "R6 setup");
        cyc(32'h0010_0008, 0, REG_STATUS, 32'h0, "R6 raise two");
        cyc(32'h0010_0008, 1, REG_STATUS, 32'h0, "R6 zero write");
        cyc(32'h0010_0008, 1, REG_STATUS, 32'h0000_0008, "R6 clear low");
        cyc(32'h0010_0008, 0, REG_STATUS, 32'h0, "R8 group1 holds");
        cyc(32'h0000_0000, 1, REG_STATUS, 32'h0010_0000, "R8 group1 drops");

        // R7 edge coincident with clear
        cyc(32'h0000_0020, 0, REG_STATUS, 32'h0, "R7 raise");
        cyc(32'h0000_0000, 0, REG_STATUS, 32'h0, "R7 low");
        cyc(32'h0000_0020, 1, REG_STATUS, 32'h0000_0020, "R7 edge wins");
        rd(REG_STATUS, 32'h0000_0020, "R7 bit kept");
        cyc(32'h0000_0020, 1, REG_STATUS, 32'hFFFF_FFFF, "R7 later clear");

        // R9 gate while pending
        cyc(32'h0000_0020, 1, REG_GRP_EN, 32'h1, "R9 gate group1");
        cyc(32'h0002_0020, 0, REG_STATUS, 32'h0, "R9 latched but gated");
        chk("R9 line1 low", {31'h0, irq[1]}, 32'h0);
        cyc(32'h0002_0020, 1, REG_GRP_EN, 32'h3, "R9 ungate");
        chk("R9 line1 high", {31'h0, irq[1]}, 32'h1);

        // R10 enables cleared: toggles do nothing, pending status kept
        cyc(32'h0002_0020, 1, REG_RISE_CLR, 32'hFFFF_FFFF, "R10 clear rise");
        cyc(32'h0002_0020, 1, REG_FALL_CLR, 32'hFFFF_FFFF, "R10 clear fall");
        cyc(32'h0000_0000, 0, REG_STATUS, 32'h0, "R10 fall edge");
        cyc(32'hFFFF_FFFF, 0, REG_STATUS, 32'h0, "R10 all rise");
        cyc(32'h0000_0000, 0, REG_STATUS, 32'h0, "R10 all fall");
        rd(REG_STATUS, 32'h0002_0000, "R10 pending kept");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule